// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block keeps a 16-bit up-counter that advances by one on every clock in which the count-enable input is high. An 8-bit bus reads it through two views, a main view and an alternate view. Each view has a high-byte location and a low-byte location. A high-byte read latches the low byte, so that the next low-byte read completes a consistent 16-bit value even though the counter keeps running. A halt input stops the count and reloads the start value FFFCh. A wait input is accepted and has no effect on counting.

Each wrap from FFFFh to 0000h raises an overflow flag. Clearing the flag takes two bus steps: read the status location while the flag is set, then read or write the main low-byte location. Accesses to the alternate view never clear the flag, so software can sample elapsed time without disturbing overflow handling. The interrupt output follows the flag only while two control bits are both set. While either bit is clear, the request stays pending.

The read-buffer state machine has two states. `RB_LIVE` moves to `RB_HELD` on a high-byte read. `RB_HELD` stays in place on further high-byte reads and returns to `RB_LIVE` on a low-byte read. The overflow state machine has three states. `OV_CLEAR` moves to `OV_PEND` on a wrap. `OV_PEND` moves to `OV_ARMED` on a status read. `OV_ARMED` returns to `OV_CLEAR` on a main low-byte access, or moves to `OV_PEND` instead if a wrap happens in that same cycle.

Top module: `coherent_timer`

## Requirements
- R1: After reset the count is FFFCh, the flag and both control bits are clear, `rdata` is 00h and `irq` is low.
- R2: On each clock with `cnt_en` high and `halt` low the count increases by one and wraps from FFFFh to 0000h. With `cnt_en` low the count holds.
- R3: While `halt` is high the count does not advance and is loaded with FFFCh. `wait_in` has no effect on counting.
- R4: A read of address 0 (main high) or address 2 (alternate high) returns count[15:8] and latches count[7:0]. The next read of address 1 or 3 returns the latched byte and releases the latch.
- R5: Further high-byte reads while the latch is held leave the latched byte unchanged.
- R6: A low-byte read (address 1 or 3) with no latch held returns the live count[7:0].
- R7: A wrap from FFFFh to 0000h sets the overflow flag. The flag reads back as bit 7 of address 4, and the other bits read 0.
- R8: The flag clears only when a read of address 4 that sees the flag set is followed by a read or write of address 1. A wrap in the same cycle as that access leaves the flag set. An access to address 1 with no prior status read leaves the flag set.
- R9: Reads or writes of addresses 2 and 3 never clear the flag.
- R10: `irq` is high exactly while the flag, control bit 0 (overflow interrupt enable) and control bit 1 (timer interrupt select) are all set. A flag raised while either bit is clear drives `irq` once both bits are set.
- R11: Read data appears on `rdata` the cycle after the read strobe and holds until the next read. Address 5 is the control register, written and read back on bits 1:0. Addresses 6 and 7 read 00h. Writes to count locations do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable for the current cycle |
| halt | input | 1 | Stop counting and reload FFFCh |
| wait_in | input | 1 | Low-power wait indication, no effect |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bus bytes and a start count of FFFCh. The start value sits four enabled cycles below the wrap, and `halt` reloads it at any moment. As a result, every overflow case can be reached within a handful of cycles without running 65536 counts. These cases are a flag raised while the interrupt is masked, a clearing access that coincides with a wrap, and a latched low byte that outlives a wrap.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_MAIN_HI = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MAIN_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ALT_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ALT_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd5;

    typedef enum logic {
        RB_LIVE,
        RB_HELD
    } rb_state_e;

    typedef enum logic [1:0] {
        OV_CLEAR,
        OV_PEND,
        OV_ARMED
    } ov_state_e;

endpackage

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
    parameter int                 CNT_W     = 16,
    parameter logic [CNT_W-1:0]   RST_COUNT = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             halt,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign wrap = cnt_en && !halt && (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= RST_COUNT;
        end else if (halt) begin
            count <= RST_COUNT;
        end else if (cnt_en) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/ctmr_readbuf.sv
module ctmr_readbuf
    import ctmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic [DATA_W-1:0] live_lo,
    output logic [DATA_W-1:0] lo_out,
    output logic [DATA_W-1:0] lo_latch,
    output logic              held
);

    rb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RB_LIVE: if (hi_rd) state_d = RB_HELD;
            RB_HELD: if (lo_rd) state_d = RB_LIVE;
            default: state_d = RB_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_latch <= '0;
        end else if (state_q == RB_LIVE && hi_rd) begin
            lo_latch <= live_lo;
        end
    end

    always_comb begin
        held   = (state_q == RB_HELD);
        lo_out = held ? lo_latch : live_lo;
    end

endmodule

// File: rtl/ctmr_ovf.sv
module ctmr_ovf
    import ctmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic stat_rd,
    input  logic main_lo_acc,
    output logic flag
);

    ov_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OV_CLEAR: if (wrap) state_d = OV_PEND;
            OV_PEND:  if (stat_rd) state_d = OV_ARMED;
            OV_ARMED: begin
                if (main_lo_acc) begin
                    state_d = wrap ? OV_PEND : OV_CLEAR;
                end
            end
            default: state_d = OV_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OV_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag = (state_q != OV_CLEAR);
    end

endmodule

// File: rtl/coherent_timer.sv
module coherent_timer
    import ctmr_pkg::*;
#(
    parameter int                    DATA_W    = 8,
    parameter logic [2*DATA_W-1:0]   RST_COUNT = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              halt,
    input  logic              wait_in,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  count;
    logic              wrap;
    logic              hi_rd, lo_rd, stat_rd, main_lo_acc;
    logic [DATA_W-1:0] lo_out, rb_lo;
    logic              rb_held;
    logic              flag;
    logic              ovie, tsel;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wait;

    assign unused_wait = wait_in;

    always_comb begin
        hi_rd       = rd_en && (addr == ADR_MAIN_HI || addr == ADR_ALT_HI);
        lo_rd       = rd_en && (addr == ADR_MAIN_LO || addr == ADR_ALT_LO);
        stat_rd     = rd_en && (addr == ADR_STATUS);
        main_lo_acc = (rd_en || wr_en) && (addr == ADR_MAIN_LO);
    end

    ctmr_counter #(
        .CNT_W     (CNT_W),
        .RST_COUNT (RST_COUNT)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .halt   (halt),
        .count  (count),
        .wrap   (wrap)
    );

    ctmr_readbuf #(
        .DATA_W (DATA_W)
    ) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_rd    (hi_rd),
        .lo_rd    (lo_rd),
        .live_lo  (count[DATA_W-1:0]),
        .lo_out   (lo_out),
        .lo_latch (rb_lo),
        .held     (rb_held)
    );

    ctmr_ovf u_ovf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .stat_rd     (stat_rd),
        .main_lo_acc (main_lo_acc),
        .flag        (flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovie <= 1'b0;
            tsel <= 1'b0;
        end else if (wr_en && addr == ADR_CTRL) begin
            ovie <= wdata[0];
            tsel <= wdata[1];
        end
    end

    always_comb begin
        unique case (addr)
            ADR_MAIN_HI, ADR_ALT_HI: rd_mux = count[CNT_W-1:DATA_W];
            ADR_MAIN_LO, ADR_ALT_LO: rd_mux = lo_out;
            ADR_STATUS:              rd_mux = {flag, {(DATA_W-1){1'b0}}};
            ADR_CTRL:                rd_mux = {{(DATA_W-2){1'b0}}, tsel, ovie};
            default:                 rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    always_comb begin
        irq = flag && ovie && tsel;
    end

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker
    import ctmr_pkg::*;
#(
    parameter int                    DATA_W    = 8,
    parameter logic [2*DATA_W-1:0]   RST_COUNT = 16'hFFFC
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cnt_en,
    input logic                  halt,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic [2:0]            addr,
    input logic [2*DATA_W-1:0]   count,
    input logic                  flag,
    input logic                  rb_held,
    input logic                  hi_rd,
    input logic [DATA_W-1:0]     rb_lo,
    input logic                  ovie,
    input logic                  tsel,
    input logic                  irq
);

    localparam logic [2*DATA_W-1:0] ONE = {{(2*DATA_W-1){1'b0}}, 1'b1};

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !halt) |=> count == $past(count) + ONE);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !halt) |=> $stable(count));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> count == RST_COUNT);

    p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_held && hi_rd) |=> $stable(rb_lo));

    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !halt && (&count)) |=> flag);

    p_alt_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && (rd_en || wr_en) && (addr == ADR_ALT_HI || addr == ADR_ALT_LO)) |=> flag);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(flag) || $rose(ovie) || $rose(tsel)));

endmodule

bind coherent_timer ctmr_checker #(
    .DATA_W    (DATA_W),
    .RST_COUNT (RST_COUNT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .halt    (halt),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .count   (count),
    .flag    (flag),
    .rb_held (rb_held),
    .hi_rd   (hi_rd),
    .rb_lo   (rb_lo),
    .ovie    (ovie),
    .tsel    (tsel),
    .irq     (irq)
);

// File: tb/sim_coherent_timer.sv
`timescale 1ns/1ps
module sim_coherent_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0, halt = 1'b0, wait_in = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    int    m_cnt, m_lat, m_rdata;
    bit    m_held, m_flag, m_armed, m_ie, m_sel;
    string m_tag = "R1";

    always #2 clk = ~clk;

    coherent_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .halt(halt), .wait_in(wait_in),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 16'hFFFC; m_lat = 0; m_rdata = 0;
            m_held = 0; m_flag = 0; m_armed = 0; m_ie = 0; m_sel = 0;
            m_tag = "R1";
        end else begin
            bit wrapnow;
            wrapnow = cnt_en && !halt && m_cnt == 16'hFFFF;
            if (rd_en) begin
                case (addr)
                    3'd0, 3'd2: begin
                        m_rdata = m_cnt >> 8;
                        if (!m_held) begin m_lat = m_cnt & 8'hFF; m_held = 1; end
                        m_tag = "R4";
                    end
                    3'd1, 3'd3: begin
                        m_rdata = m_held ? m_lat : (m_cnt & 8'hFF);
                        m_tag = m_held ? "R5" : "R6";
                        m_held = 0;
                    end
                    3'd4: begin m_rdata = m_flag ? 8'h80 : 8'h00; m_tag = "R7"; end
                    3'd5: begin m_rdata = {m_sel, m_ie}; m_tag = "R11"; end
                    default: begin m_rdata = 0; m_tag = "R11"; end
                endcase
            end
            if (rd_en && addr == 3'd4 && m_flag) m_armed = 1;
            if ((rd_en || wr_en) && addr == 3'd1) begin
                if (m_armed && m_flag) m_flag = 0;
                m_armed = 0;
            end
            if (wrapnow) m_flag = 1;
            if (wr_en && addr == 3'd5) begin m_ie = wdata[0]; m_sel = wdata[1]; end
            if (halt) m_cnt = 16'hFFFC;
            else if (cnt_en) m_cnt = (m_cnt + 1) & 16'hFFFF;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(m_tag, rdata, m_rdata);
            check("R10", irq, m_flag && m_ie && m_sel);
        end
    end

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk); cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic do_halt();
        @(negedge clk); halt = 1'b1;
        @(negedge clk); halt = 1'b0;
    endtask

    initial begin
        #(4.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rdata, 8'h00);
        check("R1", irq, 0);
        rd(3'd0, 8'hFF, "R1");
        rd(3'd1, 8'hFC, "R4");
        rd(3'd5, 8'h00, "R1");
        wr(3'd5, 8'h03);
        rd(3'd5, 8'h03, "R11");
        rd(3'd6, 8'h00, "R11");
        wr(3'd0, 8'h12);                 // count writes ignored
        rd(3'd2, 8'hFF, "R11");
        rd(3'd3, 8'hFC, "R11");
        // live low byte after two counts
        run(2);
        rd(3'd1, 8'hFE, "R6");
        rd(3'd4, 8'h00, "R2");
        // latch survives a wrap and a repeated high read
        rd(3'd0, 8'hFF, "R4");
        run(3);
        rd(3'd2, 8'h00, "R5");
        rd(3'd3, 8'hFE, "R5");
        rd(3'd1, 8'h01, "R2");
        check("R10", irq, 1);
        rd(3'd4, 8'h80, "R7");
        // alternate accesses do not clear, even after arming
        wr(3'd3, 8'h55);
        rd(3'd3, 8'h01, "R9");
        rd(3'd4, 8'h80, "R9");
        wr(3'd1, 8'h00);
        rd(3'd4, 8'h00, "R8");
        check("R10", irq, 0);
        // main access without arming leaves the flag
        wr(3'd5, 8'h00);
        do_halt();
        @(negedge clk); cnt_en = 1'b1; wait_in = 1'b1;
        repeat (4) @(negedge clk);
        cnt_en = 1'b0; wait_in = 1'b0;
        rd(3'd1, 8'h00, "R3");
        rd(3'd1, 8'h00, "R8");
        rd(3'd4, 8'h80, "R7");
        check("R10", irq, 0);
        wr(3'd5, 8'h01);
        check("R10", irq, 0);
        wr(3'd5, 8'h02);
        check("R10", irq, 0);
        wr(3'd5, 8'h03);
        check("R10", irq, 1);
        // clearing access coincides with a wrap
        do_halt();
        rd(3'd4, 8'h80, "R8");
        run(3);
        @(negedge clk); cnt_en = 1'b1; rd_en = 1'b1; addr = 3'd1;
        @(negedge clk); cnt_en = 1'b0; rd_en = 1'b0;
        check("R8", rdata, 8'hFF);
        rd(3'd4, 8'h80, "R8");
        rd(3'd1, 8'h00, "R8");
        rd(3'd4, 8'h00, "R8");
        // halt wins over count enable
        @(negedge clk); cnt_en = 1'b1; halt = 1'b1;
        repeat (3) @(negedge clk);
        halt = 1'b0; cnt_en = 1'b0;
        rd(3'd0, 8'hFF, "R3");
        rd(3'd1, 8'hFC, "R3");
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule